// File: doc/BRIEF.md
# Receive Packet FIFO with Skip and Flush

This block buffers received traffic between a receive MAC and a host. Data words arrive 32 bits at a time, with a mark on the final word of each packet. They are kept in a data ring, and each stored word carries a one-bit packet-end tag. A second, smaller ring keeps one status word per packet, written by the MAC when the packet finishes. The host pops data words and status words through two read strobes. Each strobe is answered in the same cycle by the head entry and an acceptance flag.

Two host operations act on whole packets. A skip request discards what is left of the packet at the head of the data ring. The read pointer moves one word per clock until the tagged word has been consumed. The status ring is left untouched. A flush request resets the pointers of both rings, and it is honoured only while the receiver reports itself halted. Both operations show a busy flag that drops on its own when the operation is done. While either is busy, host reads of the data ring, the status ring and the transmit status port are refused and flagged.

When the data ring is full, incoming words are dropped. The rest of that packet is dropped as well, and its status word is stored with an overflow bit forced on.

Top module: `rx_pkt_fifo`

## Requirements
- R1: During and right after reset both rings are empty, all counts are zero, and ffwd_busy, ffwd_err, dump_busy, dump_err, ovf_flag and rd_err are low.
- R2: Data words come out in write order. rd_data_last is 1 exactly on the word that was written with wr_last. With rd_data_en high and the ring not empty, rd_data_ok is high and the head is popped at the clock edge. data_cnt, data_empty and data_full follow the contents, and data_full means DEPTH words are stored.
- R3: Each st_valid stores one status word, and the status words are read back in order through rd_stat_en / rd_stat / rd_stat_ok. A status write while the status ring holds SDEPTH words is dropped and sets ovf_flag.
- R4: A word that arrives while data_full is high is dropped. So is every later word of the same packet. ovf_flag is set and stays set until a flush. The packet's status word is stored with bit 31 set to 1. If that packet stored at least one word, its last stored word gets its end tag set.
- R5: An accepted ffwd_set raises ffwd_busy from the next cycle. While the ring is not empty, one head word is discarded per clock. ffwd_busy drops at the edge that discards the tagged word, and ffwd_busy stays high while the ring is empty. stat_cnt is not changed by the skip.
- R6: ffwd_set (with ffwd_busy and dump_busy low) is accepted only if at least 4 words are stored and none of the first three head words carries the end tag. Otherwise nothing moves and ffwd_err is set. ffwd_err clears on the next accepted request.
- R7: While ffwd_busy or dump_busy is high, rd_data_en, rd_stat_en and rd_txstat_en raise rd_err in the same cycle. rd_data_ok and rd_stat_ok stay low and nothing is popped.
- R8: Writes of data and status keep being stored while a skip is running.
- R9: dump_set with rx_halted high (and ffwd_busy, dump_busy low) raises dump_busy for exactly one cycle. At the end of that cycle both rings are empty and ovf_flag is cleared. Writes during that cycle are ignored.
- R10: dump_set with rx_halted low sets dump_err and changes neither ring. dump_err clears on the next accepted flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Data word from the MAC is valid |
| wr_data | input | 32 | Data word from the MAC |
| wr_last | input | 1 | Word is the last of its packet |
| st_valid | input | 1 | Status word from the MAC is valid |
| st_data | input | 32 | Status word from the MAC |
| rx_halted | input | 1 | Receiver reports it is stopped |
| rd_data_en | input | 1 | Host pops a data word |
| rd_data | output | 32 | Head data word |
| rd_data_last | output | 1 | End tag of the head data word |
| rd_data_ok | output | 1 | Data read accepted this cycle |
| rd_stat_en | input | 1 | Host pops a status word |
| rd_stat | output | 32 | Head status word |
| rd_stat_ok | output | 1 | Status read accepted this cycle |
| rd_txstat_en | input | 1 | Host reads the transmit status port |
| rd_err | output | 1 | A read was refused because an operation is busy |
| ffwd_set | input | 1 | Request to skip the head packet |
| ffwd_busy | output | 1 | Skip in progress |
| ffwd_err | output | 1 | Last skip request was refused |
| dump_set | input | 1 | Request to flush both rings |
| dump_busy | output | 1 | Flush in progress |
| dump_err | output | 1 | Last flush request was refused |
| data_cnt | output | $clog2(DEPTH)+1 | Words stored in the data ring |
| data_empty | output | 1 | Data ring empty |
| data_full | output | 1 | Data ring full |
| stat_cnt | output | $clog2(SDEPTH)+1 | Words stored in the status ring |
| stat_empty | output | 1 | Status ring empty |
| ovf_flag | output | 1 | Sticky overflow indication |

## Verification
The bench builds the block with DEPTH=16 and SDEPTH=4. With these sizes a single 20-word packet overruns the data ring, so the drop of a packet tail, the forced end tag and the forced status bit can all be seen. Five short packets are enough to overrun the status ring. The small depths also put the skip threshold close to both sides: a 4-word packet is accepted, while 2-word and 3-word packets and an empty ring are refused. A skip runs while a new packet is still being written behind it.

// File: rtl/rx_pkt_pkg.sv
package rx_pkt_pkg;
  localparam int unsigned WORD_W       = 32;
  localparam int unsigned FFWD_MIN     = 4;   // words of head packet needed for a skip
  localparam int unsigned STAT_OVF_BIT = 31;  // status bit forced on overflow
endpackage

// File: rtl/rx_ring.sv
module rx_ring #(
  parameter int unsigned W     = 33,
  parameter int unsigned DEPTH = 64,
  parameter int unsigned PEEK  = 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         push,
  input  logic [W-1:0]                 wdata,
  input  logic                         pop,
  input  logic                         retag,
  output logic [PEEK-1:0][W-1:0]       peek,
  output logic [$clog2(DEPTH):0]       cnt
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW:0]   wr_ptr, rd_ptr, wr_ptr_n, rd_ptr_n;
  logic [AW-1:0] last_idx;

  assign last_idx = wr_ptr[AW-1:0] - AW'(1);
  assign cnt      = wr_ptr - rd_ptr;

  always_comb begin
    wr_ptr_n = wr_ptr;
    rd_ptr_n = rd_ptr;
    if (flush) begin
      wr_ptr_n = '0;
      rd_ptr_n = '0;
    end else begin
      if (push) wr_ptr_n = wr_ptr + 1'b1;
      if (pop)  rd_ptr_n = rd_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      wr_ptr <= wr_ptr_n;
      rd_ptr <= rd_ptr_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush)  mem[wr_ptr[AW-1:0]] <= wdata;
    if (retag && !flush) mem[last_idx][W-1] <= 1'b1;
  end

  for (genvar i = 0; i < PEEK; i++) begin : g_peek
    assign peek[i] = mem[rd_ptr[AW-1:0] + AW'(i)];
  end
endmodule

// File: rtl/rx_wr_gate.sv
module rx_wr_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic wr_valid,
  input  logic wr_last,
  input  logic data_full,
  input  logic st_valid,
  input  logic stat_full,
  output logic data_push,
  output logic retag,
  output logic stat_push,
  output logic stat_ovf,
  output logic ovf_flag
);
  logic dropping, stored, pend, ovf_q;
  logic dropping_n, stored_n, pend_n, ovf_n;
  logic drop_now, wr_take, st_take;

  assign wr_take   = wr_valid && !flush;
  assign st_take   = st_valid && !flush;
  assign drop_now  = wr_take && (data_full || dropping);
  assign data_push = wr_take && !data_full && !dropping;
  assign retag     = drop_now && wr_last && stored;
  assign stat_push = st_take && !stat_full;
  assign stat_ovf  = pend || drop_now;
  assign ovf_flag  = ovf_q;

  always_comb begin
    dropping_n = dropping;
    stored_n   = stored;
    pend_n     = pend;
    ovf_n      = ovf_q;
    if (flush) begin
      dropping_n = 1'b0;
      stored_n   = 1'b0;
      pend_n     = 1'b0;
      ovf_n      = 1'b0;
    end else begin
      if (wr_take) begin
        dropping_n = wr_last ? 1'b0 : (data_full || dropping);
        stored_n   = wr_last ? 1'b0 : (data_push || stored);
      end
      pend_n = st_take ? 1'b0 : (pend || drop_now);
      ovf_n  = ovf_q || drop_now || (st_take && stat_full);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dropping <= 1'b0;
      stored   <= 1'b0;
      pend     <= 1'b0;
      ovf_q    <= 1'b0;
    end else begin
      dropping <= dropping_n;
      stored   <= stored_n;
      pend     <= pend_n;
      ovf_q    <= ovf_n;
    end
  end
endmodule

// File: rtl/rx_skip_ctrl.sv
module rx_skip_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic ffwd_set,
  input  logic dump_set,
  input  logic rx_halted,
  input  logic skip_ok,
  input  logic data_empty,
  input  logic head_last,
  output logic skip_pop,
  output logic ffwd_busy,
  output logic ffwd_err,
  output logic dump_busy,
  output logic dump_err
);
  logic ffb_n, ffe_n, dmb_n, dme_n;

  assign skip_pop = ffwd_busy && !data_empty;

  always_comb begin
    ffb_n = ffwd_busy;
    ffe_n = ffwd_err;
    dmb_n = 1'b0;
    dme_n = dump_err;
    if (ffwd_busy) begin
      if (skip_pop && head_last) ffb_n = 1'b0;
    end else if (!dump_busy) begin
      if (ffwd_set) begin
        ffb_n = skip_ok;
        ffe_n = !skip_ok;
      end
      if (dump_set) begin
        dmb_n = rx_halted;
        dme_n = !rx_halted;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ffwd_busy <= 1'b0;
      ffwd_err  <= 1'b0;
      dump_busy <= 1'b0;
      dump_err  <= 1'b0;
    end else begin
      ffwd_busy <= ffb_n;
      ffwd_err  <= ffe_n;
      dump_busy <= dmb_n;
      dump_err  <= dme_n;
    end
  end
endmodule

// File: rtl/rx_pkt_fifo.sv
module rx_pkt_fifo
  import rx_pkt_pkg::*;
#(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned SDEPTH = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_valid,
  input  logic [WORD_W-1:0]         wr_data,
  input  logic                      wr_last,
  input  logic                      st_valid,
  input  logic [WORD_W-1:0]         st_data,
  input  logic                      rx_halted,
  input  logic                      rd_data_en,
  output logic [WORD_W-1:0]         rd_data,
  output logic                      rd_data_last,
  output logic                      rd_data_ok,
  input  logic                      rd_stat_en,
  output logic [WORD_W-1:0]         rd_stat,
  output logic                      rd_stat_ok,
  input  logic                      rd_txstat_en,
  output logic                      rd_err,
  input  logic                      ffwd_set,
  output logic                      ffwd_busy,
  output logic                      ffwd_err,
  input  logic                      dump_set,
  output logic                      dump_busy,
  output logic                      dump_err,
  output logic [$clog2(DEPTH):0]    data_cnt,
  output logic                      data_empty,
  output logic                      data_full,
  output logic [$clog2(SDEPTH):0]   stat_cnt,
  output logic                      stat_empty,
  output logic                      ovf_flag
);
  localparam int unsigned DW = WORD_W + 1;

  logic [FFWD_MIN-1:0][DW-1:0] dpeek;
  logic [0:0][WORD_W-1:0]      speek;
  logic data_push, retag, stat_push, stat_ovf, skip_pop, skip_ok, busy_any;
  logic stat_full, data_pop, tag_seen;
  logic [WORD_W-1:0] stat_word;

  assign busy_any   = ffwd_busy || dump_busy;
  assign data_empty = (data_cnt == '0);
  assign data_full  = (data_cnt == ($clog2(DEPTH)+1)'(DEPTH));
  assign stat_empty = (stat_cnt == '0);
  assign stat_full  = (stat_cnt == ($clog2(SDEPTH)+1)'(SDEPTH));

  assign rd_data      = dpeek[0][WORD_W-1:0];
  assign rd_data_last = dpeek[0][WORD_W];
  assign rd_data_ok   = rd_data_en && !busy_any && !data_empty;
  assign rd_stat      = speek[0];
  assign rd_stat_ok   = rd_stat_en && !busy_any && !stat_empty;
  assign rd_err       = (rd_data_en || rd_stat_en || rd_txstat_en) && busy_any;
  assign data_pop     = rd_data_ok || skip_pop;

  always_comb begin
    tag_seen = 1'b0;
    for (int i = 0; i < FFWD_MIN - 1; i++) tag_seen = tag_seen || dpeek[i][WORD_W];
    skip_ok = (data_cnt >= ($clog2(DEPTH)+1)'(FFWD_MIN)) && !tag_seen;
  end

  always_comb begin
    stat_word = st_data;
    stat_word[STAT_OVF_BIT] = st_data[STAT_OVF_BIT] || stat_ovf;
  end

  rx_ring #(.W(DW), .DEPTH(DEPTH), .PEEK(FFWD_MIN)) u_data (
    .clk(clk), .rst_n(rst_n), .flush(dump_busy), .push(data_push),
    .wdata({wr_last, wr_data}), .pop(data_pop), .retag(retag),
    .peek(dpeek), .cnt(data_cnt)
  );

  rx_ring #(.W(WORD_W), .DEPTH(SDEPTH), .PEEK(1)) u_stat (
    .clk(clk), .rst_n(rst_n), .flush(dump_busy), .push(stat_push),
    .wdata(stat_word), .pop(rd_stat_ok), .retag(1'b0),
    .peek(speek), .cnt(stat_cnt)
  );

  rx_wr_gate u_gate (
    .clk(clk), .rst_n(rst_n), .flush(dump_busy), .wr_valid(wr_valid),
    .wr_last(wr_last), .data_full(data_full), .st_valid(st_valid),
    .stat_full(stat_full), .data_push(data_push), .retag(retag),
    .stat_push(stat_push), .stat_ovf(stat_ovf), .ovf_flag(ovf_flag)
  );

  rx_skip_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .ffwd_set(ffwd_set), .dump_set(dump_set),
    .rx_halted(rx_halted), .skip_ok(skip_ok), .data_empty(data_empty),
    .head_last(rd_data_last), .skip_pop(skip_pop), .ffwd_busy(ffwd_busy),
    .ffwd_err(ffwd_err), .dump_busy(dump_busy), .dump_err(dump_err)
  );
endmodule

// File: rtl/rx_pkt_fifo_chk.sv
module rx_pkt_fifo_chk #(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned SDEPTH = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    st_valid,
  input logic                    rd_stat_en,
  input logic                    rd_data_en,
  input logic                    rd_data_ok,
  input logic                    rd_data_last,
  input logic                    rx_halted,
  input logic                    ffwd_busy,
  input logic                    dump_busy,
  input logic [$clog2(DEPTH):0]  data_cnt,
  input logic [$clog2(SDEPTH):0] stat_cnt
);
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    data_cnt <= ($clog2(DEPTH)+1)'(DEPTH));

  assert_skip_keeps_stat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ffwd_busy && !st_valid) |=> (stat_cnt == $past(stat_cnt)));

  assert_skip_ends_on_tag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ffwd_busy) |-> $past(rd_data_last));

  assert_no_read_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_en && (ffwd_busy || dump_busy)) |-> !rd_data_ok);

  assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dump_busy |=> (data_cnt == '0 && stat_cnt == '0 && !dump_busy));

  assert_flush_needs_halt_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dump_busy) |-> $past(rx_halted));

  assert_rd_stat_during_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat_en && ffwd_busy && !st_valid) |=> (stat_cnt == $past(stat_cnt)));
endmodule

bind rx_pkt_fifo rx_pkt_fifo_chk #(.DEPTH(DEPTH), .SDEPTH(SDEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .rd_stat_en(rd_stat_en),
  .rd_data_en(rd_data_en), .rd_data_ok(rd_data_ok), .rd_data_last(rd_data_last),
  .rx_halted(rx_halted), .ffwd_busy(ffwd_busy), .dump_busy(dump_busy),
  .data_cnt(data_cnt), .stat_cnt(stat_cnt)
);

// File: tb/tb_rx_pkt_fifo.sv
module tb_rx_pkt_fifo;
  localparam int DEPTH  = 16;
  localparam int SDEPTH = 4;
  localparam int CW = $clog2(DEPTH) + 1;
  localparam int SW = $clog2(SDEPTH) + 1;

  logic clk, rst_n;
  logic wr_valid, wr_last, st_valid, rx_halted, rd_data_en, rd_stat_en, rd_txstat_en;
  logic ffwd_set, dump_set;
  logic [31:0] wr_data, st_data, rd_data, rd_stat;
  logic rd_data_last, rd_data_ok, rd_stat_ok, rd_err, ffwd_busy, ffwd_err;
  logic dump_busy, dump_err, data_empty, data_full, stat_empty, ovf_flag;
  logic [CW-1:0] data_cnt;
  logic [SW-1:0] stat_cnt;

  rx_pkt_fifo #(.DEPTH(DEPTH), .SDEPTH(SDEPTH)) dut (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // reference model state
  logic [31:0] m_dq[$];
  bit          m_dt[$];
  logic [31:0] m_sq[$];
  bit m_ffb, m_ffe, m_dmb, m_dme, m_ovf, m_drop, m_stored, m_pend;

  int vectors = 0, miscompares = 0, cycles = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dq.delete(); m_dt.delete(); m_sq.delete();
      m_ffb = 0; m_ffe = 0; m_dmb = 0; m_dme = 0;
      m_ovf = 0; m_drop = 0; m_stored = 0; m_pend = 0;
    end else begin
      int  sz;
      bit  fullp, sfull, elig, ffb0, dropn, pushed;
      sz    = m_dq.size();
      fullp = (sz == DEPTH);
      sfull = (m_sq.size() == SDEPTH);
      elig  = (sz >= 4) && !m_dt[0] && !m_dt[1] && !m_dt[2];
      ffb0  = m_ffb;
      if (m_dmb) begin
        m_dq.delete(); m_dt.delete(); m_sq.delete();
        m_ovf = 0; m_drop = 0; m_stored = 0; m_pend = 0; m_dmb = 0;
      end else begin
        if (rd_data_en && !ffb0 && sz > 0) begin
          void'(m_dq.pop_front()); void'(m_dt.pop_front());
        end
        if (ffb0 && sz > 0) begin
          void'(m_dq.pop_front());
          if (m_dt.pop_front()) m_ffb = 0;
        end
        if (rd_stat_en && !ffb0 && m_sq.size() > 0) void'(m_sq.pop_front());
        dropn  = wr_valid && (fullp || m_drop);
        pushed = wr_valid && !fullp && !m_drop;
        if (pushed) begin m_dq.push_back(wr_data); m_dt.push_back(wr_last); end
        if (dropn && wr_last && m_stored) m_dt[m_dt.size()-1] = 1;
        if (st_valid) begin
          if (sfull) m_ovf = 1;
          else m_sq.push_back(st_data | ((m_pend || dropn) ? 32'h8000_0000 : 32'h0));
        end
        m_pend = st_valid ? 0 : (m_pend || dropn);
        if (dropn) m_ovf = 1;
        if (wr_valid) begin
          m_stored = wr_last ? 0 : (pushed || m_stored);
          m_drop   = wr_last ? 0 : (fullp || m_drop);
        end
        if (!ffb0) begin
          if (ffwd_set) begin m_ffb = elig; m_ffe = !elig; end
          if (dump_set) begin m_dmb = rx_halted; m_dme = !rx_halted; end
        end
      end
    end
  end

  // compare every cycle, 1 ns after the falling edge where inputs change
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      bit busy;
      busy = m_ffb || m_dmb;
      chk("R2 data_cnt", 32'(data_cnt), 32'(m_dq.size()));
      chk("R2 data_empty", 32'(data_empty), 32'(m_dq.size() == 0));
      chk("R2 data_full", 32'(data_full), 32'(m_dq.size() == DEPTH));
      if (m_dq.size() > 0) begin
        chk("R2 rd_data", rd_data, m_dq[0]);
        chk("R4 rd_data_last tag", 32'(rd_data_last), 32'(m_dt[0]));
      end
      chk("R7 rd_data_ok", 32'(rd_data_ok), 32'(rd_data_en && !busy && m_dq.size() > 0));
      chk("R3 stat_cnt", 32'(stat_cnt), 32'(m_sq.size()));
      chk("R3 stat_empty", 32'(stat_empty), 32'(m_sq.size() == 0));
      if (m_sq.size() > 0) chk("R3 R4 rd_stat", rd_stat, m_sq[0]);
      chk("R7 rd_stat_ok", 32'(rd_stat_ok), 32'(rd_stat_en && !busy && m_sq.size() > 0));
      chk("R7 rd_err", 32'(rd_err), 32'((rd_data_en || rd_stat_en || rd_txstat_en) && busy));
      chk("R5 R8 ffwd_busy", 32'(ffwd_busy), 32'(m_ffb));
      chk("R6 ffwd_err", 32'(ffwd_err), 32'(m_ffe));
      chk("R9 dump_busy", 32'(dump_busy), 32'(m_dmb));
      chk("R10 dump_err", 32'(dump_err), 32'(m_dme));
      chk("R4 ovf_flag", 32'(ovf_flag), 32'(m_ovf));
    end
  end

  task automatic clr();
    wr_valid = 0; wr_last = 0; wr_data = '0; st_valid = 0; st_data = '0;
    rd_data_en = 0; rd_stat_en = 0; rd_txstat_en = 0; ffwd_set = 0; dump_set = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); clr(); end
  endtask

  task automatic put(input logic [31:0] d, input bit last);
    @(negedge clk); clr();
    wr_valid = 1; wr_data = d; wr_last = last;
    st_valid = last; st_data = 32'h5a00_0000 | d;
  endtask

  task automatic pkt(input logic [31:0] base, input int len);
    for (int i = 0; i < len; i++) put(base + 32'(i), i == len - 1);
  endtask

  task automatic rdd(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); clr(); rd_data_en = 1; end
  endtask

  task automatic rds(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); clr(); rd_stat_en = 1; end
  endtask

  task automatic ffwd();
    @(negedge clk); clr(); ffwd_set = 1;
  endtask

  task automatic dump();
    @(negedge clk); clr(); dump_set = 1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog actual=%0d expected<=20000 cycles", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst_n = 0; rx_halted = 0; clr();
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state
    chk("R1 data_cnt", 32'(data_cnt), 0);
    chk("R1 stat_cnt", 32'(stat_cnt), 0);
    chk("R1 data_empty", 32'(data_empty), 1);
    chk("R1 stat_empty", 32'(stat_empty), 1);
    chk("R1 flags", {26'd0, ffwd_busy, ffwd_err, dump_busy, dump_err, ovf_flag, rd_err}, 0);
    @(negedge clk); rst_n = 1;
    // R2 R3: three packets, in-order reads
    pkt(100, 5); pkt(200, 2); pkt(300, 3);
    rdd(5); rds(1);
    // R6: head packet of 2 words refused
    ffwd(); idle(2);
    rdd(2); rds(1);
    // R6: head packet of 3 words refused
    ffwd(); idle(2);
    rdd(3); rds(1);
    // R6: empty ring refused
    ffwd(); idle(2);
    // R5 R7 R8: skip a 6-word packet while writing and reading
    pkt(400, 6); pkt(500, 4);
    ffwd();
    put(600, 0); rd_stat_en = 1;
    put(601, 0); rd_data_en = 1;
    put(602, 1); rd_txstat_en = 1;
    idle(6);
    // R5 R6: exactly 4 words accepted
    ffwd(); idle(6);
    rds(3); rdd(3);
    // R4: overflow of data ring, then of status ring
    pkt(700, 20); pkt(800, 2);
    pkt(900, 1); pkt(910, 1); pkt(920, 1);
    idle(2);
    rdd(4); rds(1);
    // R10: flush refused while running
    dump(); idle(2);
    // R9: flush while halted, write during busy cycle ignored
    rx_halted = 1;
    dump();
    put(950, 1);
    idle(2);
    rx_halted = 0;
    pkt(1000, 2); rdd(2); rds(1);
    idle(3);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule